// File: doc/BRIEF.md
# Grayscale PWM Controller with Timing Reset

This block drives the on/off enables of a bank of constant-current output channels by pulse-width modulation. One free-running grayscale counter advances on each rising edge of a reference clock. Every channel compares the counter against its own grayscale value, and the channel is on while the counter is below that value. The reference clock is either an internal clock at half the system clock rate or an external pin. The output update edge can be set to the rising or the falling edge of that reference. Devices in a chain can use opposite settings so that they do not all switch in the same instant.

New grayscale values and four control flags arrive over a two-wire serial link, a data pin and a serial clock pin. Both pins are synchronous to `clk`. No latch pin exists. The block notices that the serial clock has stopped and produces an internal latch pulse. The pulse copies the shifted word into the active registers. If the timing-reset flag is set in the new word, or if the blank flag changes, the same pulse also restarts the PWM period and turns every channel off.

Top module: `gspwm_ctrl`

## Requirements
- R1: On each `clk` edge where `ser_clk` is 1 and was 0 at the previous edge, `ser_dat` shifts into a word of NCH*GSW+4 bits, most significant bit first. Bits [i*GSW +: GSW] hold the grayscale value of channel i. Bit NCH*GSW is the timing-reset flag, +1 selects the external reference, +2 selects rising-edge output update, and +3 is blank. This word reaches the active registers only at the latch pulse.
- R2: On each rising reference edge, channel i's enable register captures (counter < grayscale[i]) and the counter increments by one, wrapping from 2^GSW-1 to 0.
- R3: Between rising reference edges the counter holds its value.
- R4: A latch pulse whose new word has the timing-reset flag at 1 clears the counter and both enable registers in that cycle. The first comparison after that happens on the next rising reference edge.
- R5: A latch pulse with the timing-reset flag at 0 and blank unchanged disturbs neither the counter nor the outputs. Only the new grayscale values take effect at later comparisons.
- R6: A latch pulse that changes blank, from 0 to 1 or from 1 to 0, restarts exactly as in R4 whatever the timing-reset flag holds.
- R7: While the active blank flag is 1, `ch_on` is all zeros.
- R8: With the rising-edge update flag at 1, `ch_on` changes only on rising reference edges or latch pulses. With the flag at 0, `ch_on` follows the enable captured at the preceding rising edge and changes only on falling reference edges or latch pulses.
- R9: With the reference-select flag at 0, the reference toggles on every `clk` edge, which gives a rising edge every two cycles. With the flag at 1, the reference is `gs_ext_clk`.
- R10: The latch pulse fires once, on the edge that lies max(8*P, MIN_IDLE) cycles after the last serial clock rise. P is the cycle distance between the last two rises. A frame needs at least two rises.
- R11: After reset the outputs are off, the counter is 0 and every control flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data, captured on `ser_clk` rises |
| gs_ext_clk | input | 1 | External grayscale reference, sampled by `clk` |
| ch_on | output | NCH | Per-channel current-sink enable |

## Verification
The sharpest collision is a latch-driven restart that falls in the same cycle as a rising reference edge, or, in falling-edge mode, as an output update. The restart must win: the counter reads 0 and the first comparison waits for the next rising edge. The internal reference rises every other cycle, and frames are sent at two serial rates, so latch pulses land on both reference phases. The external reference has a period of six cycles. A behavioural model in the bench recomputes every channel every cycle, and any disagreement at a coincidence cycle is reported. Duty counts over whole PWM periods and a check of the latch instant complete the picture.

// File: rtl/gspwm_pkg.sv
`timescale 1ns/1ps
package gspwm_pkg;
  localparam int CFG_BITS = 4;

  // packed low to high: timing reset, external ref, rising update, blank
  typedef struct packed {
    logic blank;
    logic out_rise;
    logic ref_ext;
    logic tmg_rst;
  } gspwm_cfg_t;
endpackage

// File: rtl/gspwm_serin.sv
`timescale 1ns/1ps
module gspwm_serin
  import gspwm_pkg::*;
#(
  parameter int NCH      = 12,
  parameter int GSW      = 16,
  parameter int IDW      = 16,
  parameter int MIN_IDLE = 8,
  localparam int WW      = NCH * GSW + CFG_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  output logic          lat_p,
  output logic [WW-1:0] word
);
  localparam int            TW       = IDW + 4;
  localparam logic [IDW-1:0] IDLE_MAX = '1;
  localparam logic [TW-1:0]  THR_MIN  = TW'(MIN_IDLE);

  logic           sclk_d;
  logic           armed;
  logic           rise;
  logic [IDW-1:0] idle;
  logic [IDW-1:0] per;
  logic [IDW-1:0] idle_inc;
  logic [TW-1:0]  thr_raw;
  logic [TW-1:0]  thr;
  logic [TW-1:0]  gap;

  always_comb begin
    rise     = ser_clk & ~sclk_d;
    idle_inc = (idle == IDLE_MAX) ? IDLE_MAX : idle + 1'b1;
    thr_raw  = {1'b0, per, 3'b000};
    thr      = (thr_raw < THR_MIN) ? THR_MIN : thr_raw;
    gap      = TW'(idle) + 1'b1;
    lat_p    = armed & ~rise & (gap >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      armed  <= 1'b0;
      idle   <= '0;
      per    <= IDLE_MAX;
      word   <= '0;
    end else begin
      sclk_d <= ser_clk;
      if (rise) begin
        word  <= {word[WW-2:0], ser_dat};
        idle  <= '0;
        per   <= armed ? idle_inc : IDLE_MAX;
        armed <= 1'b1;
      end else begin
        idle <= idle_inc;
        if (lat_p) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gspwm_refsel.sv
`timescale 1ns/1ps
module gspwm_refsel #(
  parameter int HALF_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic ext_clk,
  output logic ref_rise,
  output logic ref_fall
);
  logic int_ref;
  logic ref_prev;
  logic ref_lvl;

  generate
    if (HALF_DIV <= 1) begin : g_toggle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_ref <= 1'b0;
        else        int_ref <= ~int_ref;
      end
    end else begin : g_divider
      localparam int DW = $clog2(HALF_DIV);
      localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
      logic [DW-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div     <= '0;
          int_ref <= 1'b0;
        end else if (div == LAST) begin
          div     <= '0;
          int_ref <= ~int_ref;
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    ref_lvl  = use_ext ? ext_clk : int_ref;
    ref_rise = ref_lvl & ~ref_prev;
    ref_fall = ~ref_lvl & ref_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= ref_lvl;
  end
endmodule

// File: rtl/gspwm_core.sv
`timescale 1ns/1ps
module gspwm_core #(
  parameter int NCH = 12,
  parameter int GSW = 16,
  localparam int GSB = NCH * GSW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_rise,
  input  logic           ref_fall,
  input  logic           restart,
  input  logic           out_rise,
  input  logic           blank,
  input  logic [GSB-1:0] gs_flat,
  output logic [NCH-1:0] ch_on,
  output logic [GSW-1:0] cnt
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] cmp_r;
  logic [NCH-1:0] cmp_f;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
      assign hit[g] = (cnt < gs_flat[g*GSW +: GSW]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmp_r <= '0;
      cmp_f <= '0;
    end else if (restart) begin
      cnt   <= '0;
      cmp_r <= '0;
      cmp_f <= '0;
    end else begin
      if (ref_fall) cmp_f <= cmp_r;
      if (ref_rise) begin
        cmp_r <= hit;
        cnt   <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (blank)         ch_on = '0;
    else if (out_rise) ch_on = cmp_r;
    else               ch_on = cmp_f;
  end
endmodule

// File: rtl/gspwm_ctrl.sv
`timescale 1ns/1ps
module gspwm_ctrl
  import gspwm_pkg::*;
#(
  parameter int NCH          = 12,
  parameter int GSW          = 16,
  parameter int IDW          = 16,
  parameter int MIN_IDLE     = 8,
  parameter int REF_HALF_DIV = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           gs_ext_clk,
  output logic [NCH-1:0] ch_on
);
  localparam int GSB = NCH * GSW;
  localparam int WW  = GSB + CFG_BITS;

  logic           lat_p;
  logic [WW-1:0]  word;
  gspwm_cfg_t     cfg_in;
  gspwm_cfg_t     cfg_q;
  logic [GSB-1:0] gs_q;
  logic           restart;
  logic           ref_rise;
  logic           ref_fall;
  logic [GSW-1:0] cnt;

  gspwm_serin #(
    .NCH(NCH), .GSW(GSW), .IDW(IDW), .MIN_IDLE(MIN_IDLE)
  ) u_serin (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .lat_p(lat_p), .word(word)
  );

  assign cfg_in  = gspwm_cfg_t'(word[GSB +: CFG_BITS]);
  assign restart = lat_p & (cfg_in.tmg_rst | (cfg_in.blank ^ cfg_q.blank));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      gs_q  <= '0;
    end else if (lat_p) begin
      cfg_q <= cfg_in;
      gs_q  <= word[GSB-1:0];
    end
  end

  gspwm_refsel #(.HALF_DIV(REF_HALF_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .use_ext(cfg_q.ref_ext), .ext_clk(gs_ext_clk),
    .ref_rise(ref_rise), .ref_fall(ref_fall)
  );

  gspwm_core #(.NCH(NCH), .GSW(GSW)) u_core (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .restart(restart), .out_rise(cfg_q.out_rise), .blank(cfg_q.blank),
    .gs_flat(gs_q), .ch_on(ch_on), .cnt(cnt)
  );
endmodule

// File: rtl/gspwm_ctrl_chk.sv
`timescale 1ns/1ps
module gspwm_ctrl_chk #(
  parameter int NCH = 12,
  parameter int GSW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lat_p,
  input logic           restart,
  input logic           ref_rise,
  input logic           ref_fall,
  input logic           out_rise,
  input logic           blank,
  input logic [GSW-1:0] cnt,
  input logic [NCH-1:0] ch_on
);
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (ch_on == '0)); // R7

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && ch_on == '0)); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ref_rise) |=> $stable(cnt)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && ref_rise) |=> (cnt == GSW'($past(cnt) + 1'b1))); // R2

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_p && !(out_rise ? ref_rise : ref_fall)) |=> $stable(ch_on)); // R8

  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lat_p |=> !lat_p); // R10
endmodule

bind gspwm_ctrl gspwm_ctrl_chk #(.NCH(NCH), .GSW(GSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_p(lat_p), .restart(restart),
  .ref_rise(ref_rise), .ref_fall(ref_fall), .out_rise(cfg_q.out_rise),
  .blank(cfg_q.blank), .cnt(cnt), .ch_on(ch_on)
);

// File: tb/gspwm_ctrl_test.sv
`timescale 1ns/1ps
module gspwm_ctrl_test;
  localparam int NCH = 3;
  localparam int GSW = 6;
  localparam int IDW = 16;
  localparam int MIN_IDLE = 24;
  localparam int GSB = NCH * GSW;
  localparam int WW = GSB + 4;
  localparam int GMOD = 1 << GSW;
  localparam int SAT = (1 << IDW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic gs_ext_clk = 1'b0;
  logic [NCH-1:0] ch_on;

  always #10 clk = ~clk;

  gspwm_ctrl #(.NCH(NCH), .GSW(GSW), .IDW(IDW), .MIN_IDLE(MIN_IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .gs_ext_clk(gs_ext_clk), .ch_on(ch_on)
  );

  int checks = 0;
  int errors = 0;
  int edge_no = 0;
  bit done = 0;
  string cur_req = "R11";

  // behavioural reference state
  bit m_sclk, m_armed, m_iref, m_refp, m_tmg, m_ext, m_rise, m_blank;
  int m_idle, m_per, m_cnt;
  int m_gs[NCH];
  bit m_cmp[NCH];
  bit m_cmpf[NCH];
  bit mq[$];

  always @(posedge clk) begin
    bit r, lp, lvl, rr, rf, rs;
    int thr;
    logic [WW-1:0] nw;
    edge_no++;
    if (!rst_n) begin
      m_sclk = 0; m_armed = 0; m_iref = 0; m_refp = 0;
      m_tmg = 0; m_ext = 0; m_rise = 0; m_blank = 0;
      m_idle = 0; m_per = SAT; m_cnt = 0;
      for (int i = 0; i < NCH; i++) begin m_gs[i] = 0; m_cmp[i] = 0; m_cmpf[i] = 0; end
      mq.delete();
    end else begin
      r = ser_clk && !m_sclk;
      thr = 8 * m_per;
      if (thr < MIN_IDLE) thr = MIN_IDLE;
      lp = m_armed && !r && (m_idle + 1 >= thr);
      lvl = m_ext ? gs_ext_clk : m_iref;
      rr = lvl && !m_refp;
      rf = !lvl && m_refp;
      nw = '0;
      for (int k = 0; k < mq.size(); k++) nw = {nw[WW-2:0], mq[k]};
      rs = lp && (nw[GSB] || (nw[GSB+3] != m_blank));
      if (rs) begin
        m_cnt = 0;
        for (int i = 0; i < NCH; i++) begin m_cmp[i] = 0; m_cmpf[i] = 0; end
      end else begin
        if (rf) for (int i = 0; i < NCH; i++) m_cmpf[i] = m_cmp[i];
        if (rr) begin
          for (int i = 0; i < NCH; i++) m_cmp[i] = (m_cnt < m_gs[i]);
          m_cnt = (m_cnt + 1) % GMOD;
        end
      end
      m_sclk = ser_clk;
      if (r) begin
        mq.push_back(ser_dat);
        if (mq.size() > WW) void'(mq.pop_front());
        m_per = m_armed ? ((m_idle + 1 > SAT) ? SAT : m_idle + 1) : SAT;
        m_idle = 0;
        m_armed = 1;
      end else begin
        if (m_idle < SAT) m_idle++;
        if (lp) m_armed = 0;
      end
      m_refp = lvl;
      m_iref = !m_iref;
      if (lp) begin
        m_tmg = nw[GSB]; m_ext = nw[GSB+1]; m_rise = nw[GSB+2]; m_blank = nw[GSB+3];
        for (int i = 0; i < NCH; i++) m_gs[i] = int'(nw[i*GSW +: GSW]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [NCH-1:0] exp;
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++)
        exp[i] = m_blank ? 1'b0 : (m_rise ? m_cmp[i] : m_cmpf[i]);
      checks++;
      if (ch_on !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d ch_on actual %b expected %b", cur_req, edge_no, ch_on, exp);
      end
    end
  end

  initial forever begin
    repeat (3) @(negedge clk);
    gs_ext_clk = ~gs_ext_clk;
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(bit blank, bit rise, bit ext, bit tmg,
                                       int g0, int g1, int g2);
    logic [WW-1:0] w;
    w = '0;
    w[0*GSW +: GSW] = GSW'(g0);
    w[1*GSW +: GSW] = GSW'(g1);
    w[2*GSW +: GSW] = GSW'(g2);
    w[GSB +: 4] = {blank, rise, ext, tmg};
    return w;
  endfunction

  task automatic send_frame(logic [WW-1:0] w, int half, output int lat_edge);
    int last;
    int thr;
    last = 0;
    for (int b = WW - 1; b >= 0; b--) begin
      @(negedge clk);
      ser_dat = w[b];
      ser_clk = 1'b0;
      repeat (half) @(negedge clk);
      ser_clk = 1'b1;
      if (b == 0) last = edge_no + 1;
      repeat (half - 1) @(negedge clk);
    end
    @(negedge clk);
    ser_clk = 1'b0;
    thr = 16 * half;
    if (thr < MIN_IDLE) thr = MIN_IDLE;
    lat_edge = last + thr;
  endtask

  task automatic wait_edge(int n);
    while (edge_no < n) @(negedge clk);
  endtask

  task automatic duty(string req, int n, int e0, int e1, int e2);
    int c[NCH];
    for (int i = 0; i < NCH; i++) c[i] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (ch_on[i]) c[i]++;
    end
    check(req, c[0], e0);
    check(req, c[1], e1);
    check(req, c[2], e2);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset outputs off", int'(ch_on), 0);

    // R1, R10, R4: first frame, short serial period so MIN_IDLE decides
    cur_req = "R1";
    send_frame(mk(0, 1, 0, 1, 10, 40, 63), 1, lat);
    wait_edge(lat - 1);
    check("R10 no early update", int'(ch_on), 0);
    wait_edge(lat + 2);
    check("R4 restart then first compare", int'(ch_on), 7);
    cur_req = "R2";
    wait_edge(lat + 200);
    duty("R2 duty internal ref", 128, 20, 80, 126);

    // R5, R8: no reset flag, falling-edge update, slower serial rate
    cur_req = "R5";
    send_frame(mk(0, 0, 0, 0, 10, 40, 63), 2, lat);
    wait_edge(lat + 10);
    cur_req = "R8";
    duty("R8 duty falling update", 128, 20, 80, 126);

    // R4 with outputs running
    cur_req = "R4";
    send_frame(mk(0, 1, 0, 1, 63, 63, 63), 2, lat);
    wait_edge(lat);
    check("R4 forced off at latch", int'(ch_on), 0);
    wait_edge(lat + 2);
    check("R4 on at next rising ref edge", int'(ch_on), 7);

    // R7: blank set (also restarts per R6)
    cur_req = "R7";
    send_frame(mk(1, 1, 0, 0, 63, 63, 63), 1, lat);
    wait_edge(lat);
    duty("R7 blank keeps outputs dark", 100, 0, 0, 0);

    // R6: blank cleared with reset flag 0 still restarts
    cur_req = "R6";
    send_frame(mk(0, 1, 0, 0, 20, 20, 20), 1, lat);
    wait_edge(lat);
    check("R6 off at blank change", int'(ch_on), 0);
    wait_edge(lat + 2);
    check("R6 restart from zero", int'(ch_on), 7);
    wait_edge(lat + 150);

    // R9: external reference, period 6 cycles, boundary values 0 and 1
    cur_req = "R9";
    send_frame(mk(0, 0, 1, 1, 0, 1, 63), 1, lat);
    wait_edge(lat + 400);
    duty("R9 duty external ref", 384, 0, 6, 378);

    cur_req = "R8";
    send_frame(mk(0, 1, 1, 0, 0, 1, 63), 2, lat);
    wait_edge(lat + 400);
    duty("R8 duty rising update ext", 384, 0, 6, 378);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R10 watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule